// File: doc/BRIEF.md
# Clock Output Gating and Strap Controller

This block is the digital control that sits around a multi-output system clock generator. It receives one free-running source clock for each output group (CPU pairs, serial-reference pair, PCI, free-running PCI and 3.3 V auxiliary) and returns gated copies of them. It also returns a two-bit frequency-mode code and two output-rate select bits.

Four strap pins are sampled on the control clock while the active-low power-good qualifier is low. Their values are frozen as soon as the qualifier goes high. One active-low shared input has two possible meanings, and a configuration bit picks between them:

- With the bit clear, the input is a power-down request. It stops every output at once, without waiting for a clock edge.
- With the bit set, the input is a safe-frequency request. It replaces the frequency-mode code with a fixed parameter value and leaves the clocks running.

A separate active-low PCI-stop request parks the PCI group and the serial-reference pair low. The request is synchronised so that it takes effect only on clock edges.

Every synchronous stop and restart passes through a two-flop synchroniser clocked on the falling edge of the group's own clock. The enable therefore changes only while that clock is low, and no shortened pulse is produced. All pins are plain level-sensitive control or clock signals, so the block has no streaming interface and no back-pressure.

Top module: `clkgate_strap_ctrl`

## Requirements
- R1: While `pg_n` is low, each rising edge of `ctl_clk` captures the straps. Field mapping: `freq_mode[1]` is the latched `strap_fs_b` and `freq_mode[0]` is the latched `strap_fs_a`. This holds when no safe-frequency request is active.
- R2: While `pg_n` is high, the latched straps and every output derived from them stay unchanged, whatever the strap pins do.
- R3: `vch_is48` follows the latched `strap_vch` (1 = 48 MHz, 0 = 66.66 MHz). `usb_is24` follows the latched `strap_usb` (1 = 24 MHz, 0 = 48 MHz).
- R4: With `cfg_safe` = 0, a low `shared_n` stops all outputs without waiting for any clock edge. Every true or single-ended output goes low, and every complement output goes high.
- R5: With `cfg_safe` = 1, a low `shared_n` forces `freq_mode` to `SAFE_CODE` (default 2'b00) and stops no clock. With `shared_n` high, `cfg_safe` has no effect.
- R6: A low `pci_stop_n` parks `pci_out` low, `src_t` low and `src_c` high within three falling edges of the group's clock.
- R7: `pci_stop_n` has no effect on `pcif_out`, `cpu_t`/`cpu_c` or `aux_out`.
- R8: After a stop request is released, the outputs restart within three falling edges. Every high pulse of a gated output, apart from one cut short by power-down, is a full high phase of its source clock.
- R9: When power-down is released, each group restarts through its own synchroniser. A PCI-stop request that is still held keeps the PCI and serial-reference outputs parked.
- R10: While `rst_n` is low, all outputs are stopped, the latched straps are 0 and `freq_mode` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control clock for strap capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_n | input | 1 | Active-low power-good qualifier; straps are captured while it is low |
| strap_fs_a | input | 1 | Frequency strap A |
| strap_fs_b | input | 1 | Frequency strap B |
| strap_vch | input | 1 | Auxiliary-rate strap (1 = 48 MHz) |
| strap_usb | input | 1 | USB-rate strap (1 = 24 MHz) |
| cfg_safe | input | 1 | 0: shared pin means power-down, 1: shared pin means safe-frequency |
| shared_n | input | 1 | Active-low shared request pin |
| pci_stop_n | input | 1 | Active-low PCI/serial-reference stop request |
| cpu_clk_in | input | 1 | Free-running CPU group source clock |
| src_clk_in | input | 1 | Free-running serial-reference source clock |
| pci_clk_in | input | 1 | Free-running PCI group source clock |
| pcif_clk_in | input | 1 | Free-running PCIF group source clock |
| aux_clk_in | input | 1 | Free-running 3.3 V auxiliary group source clock |
| cpu_t | output | NCPU | CPU pairs, true legs |
| cpu_c | output | NCPU | CPU pairs, complement legs |
| src_t | output | 1 | Serial reference, true leg |
| src_c | output | 1 | Serial reference, complement leg |
| pci_out | output | NPCI | Stoppable PCI clocks |
| pcif_out | output | NPCIF | Free-running PCI clocks |
| aux_out | output | NAUX | 3.3 V auxiliary clocks |
| freq_mode | output | 2 | Frequency-mode code |
| vch_is48 | output | 1 | Latched auxiliary-rate select |
| usb_is24 | output | 1 | Latched USB-rate select |

## Verification
Two pairs of functions can fall in the same cycle, and the bench provokes both.

- Power-down and PCI-stop: the bench asserts both in one step, then releases power-down while PCI-stop is still held. It judges the result by checking that the CPU, PCIF and auxiliary groups restart while the PCI and serial-reference outputs stay parked, and that they resume only after PCI-stop is also released.
- Safe-frequency and strap capture: the bench raises the safe-frequency request while the qualifier is low and the straps are moving. It checks that `freq_mode` shows the safe code, and that it reverts to the freshly latched straps once the request drops.

Exhaustive sweeps over the sixteen strap values and the four pin-function combinations give the expected codes arithmetically. A pulse-width monitor on gated outputs catches any shortened pulse.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

  // Meaning of the shared active-low request pin after decoding.
  typedef enum logic [1:0] {
    PIN_IDLE  = 2'b00,
    PIN_PWRDN = 2'b01,
    PIN_SAFE  = 2'b10
  } pin_fn_e;

  // Strap bundle captured under the power-good qualifier.
  typedef struct packed {
    logic fs_b;
    logic fs_a;
    logic vch48;
    logic usb24;
  } strap_t;

  localparam int FMODE_W = 2;

endpackage

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
module strap_latch
  import clkgate_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   qual_n,
  input  strap_t raw,
  output strap_t held
);

  // Transparent sampling while the qualifier is low, frozen when it is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else if (!qual_n) begin
      held <= raw;
    end
  end

endmodule

// File: rtl/pin_func_decode.sv
`timescale 1ns/1ps
module pin_func_decode
  import clkgate_pkg::*;
(
  input  logic    cfg_safe,
  input  logic    shared_n,
  output pin_fn_e fn,
  output logic    pd_req,
  output logic    safe_req
);

  always_comb begin
    if (shared_n) begin
      fn = PIN_IDLE;
    end else if (cfg_safe) begin
      fn = PIN_SAFE;
    end else begin
      fn = PIN_PWRDN;
    end
  end

  assign pd_req   = (fn == PIN_PWRDN);
  assign safe_req = (fn == PIN_SAFE);

endmodule

// File: rtl/clk_group_gate.sv
`timescale 1ns/1ps
module clk_group_gate #(
  parameter int WIDTH = 1
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             pd_req,
  input  logic             stop_req,
  output logic [WIDTH-1:0] gclk
);

  logic arst_n;
  logic sync_a;
  logic sync_b;

  // Power-down clears the enable at once; reset does the same.
  assign arst_n = rst_n & ~pd_req;

  // Falling-edge synchroniser: the enable only moves while clk_in is low.
  always_ff @(negedge clk_in or negedge arst_n) begin
    if (!arst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
    end else begin
      sync_a <= ~stop_req;
      sync_b <= sync_a;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign gclk[i] = clk_in & sync_b;
  end

endmodule

// File: rtl/clkgate_strap_ctrl.sv
`timescale 1ns/1ps
module clkgate_strap_ctrl
  import clkgate_pkg::*;
#(
  parameter int                 NCPU      = 3,
  parameter int                 NPCI      = 7,
  parameter int                 NPCIF     = 3,
  parameter int                 NAUX      = 4,
  parameter logic [FMODE_W-1:0] SAFE_CODE = 2'b00
) (
  input  logic               ctl_clk,
  input  logic               rst_n,
  input  logic               pg_n,
  input  logic               strap_fs_a,
  input  logic               strap_fs_b,
  input  logic               strap_vch,
  input  logic               strap_usb,
  input  logic               cfg_safe,
  input  logic               shared_n,
  input  logic               pci_stop_n,
  input  logic               cpu_clk_in,
  input  logic               src_clk_in,
  input  logic               pci_clk_in,
  input  logic               pcif_clk_in,
  input  logic               aux_clk_in,
  output logic [NCPU-1:0]    cpu_t,
  output logic [NCPU-1:0]    cpu_c,
  output logic               src_t,
  output logic               src_c,
  output logic [NPCI-1:0]    pci_out,
  output logic [NPCIF-1:0]   pcif_out,
  output logic [NAUX-1:0]    aux_out,
  output logic [FMODE_W-1:0] freq_mode,
  output logic               vch_is48,
  output logic               usb_is24
);

  strap_t  raw_straps;
  strap_t  held_straps;
  pin_fn_e pin_fn;
  logic    pd_req;
  logic    safe_req;
  logic    pci_stop_req;
  logic    src_gclk;

  assign raw_straps = '{fs_b: strap_fs_b, fs_a: strap_fs_a,
                        vch48: strap_vch, usb24: strap_usb};

  strap_latch u_straps (
    .clk    (ctl_clk),
    .rst_n  (rst_n),
    .qual_n (pg_n),
    .raw    (raw_straps),
    .held   (held_straps)
  );

  pin_func_decode u_pinfn (
    .cfg_safe (cfg_safe),
    .shared_n (shared_n),
    .fn       (pin_fn),
    .pd_req   (pd_req),
    .safe_req (safe_req)
  );

  assign pci_stop_req = ~pci_stop_n;

  clk_group_gate #(.WIDTH(NCPU)) u_cpu (
    .clk_in (cpu_clk_in), .rst_n (rst_n), .pd_req (pd_req),
    .stop_req (1'b0), .gclk (cpu_t)
  );

  clk_group_gate #(.WIDTH(1)) u_src (
    .clk_in (src_clk_in), .rst_n (rst_n), .pd_req (pd_req),
    .stop_req (pci_stop_req), .gclk (src_gclk)
  );

  clk_group_gate #(.WIDTH(NPCI)) u_pci (
    .clk_in (pci_clk_in), .rst_n (rst_n), .pd_req (pd_req),
    .stop_req (pci_stop_req), .gclk (pci_out)
  );

  clk_group_gate #(.WIDTH(NPCIF)) u_pcif (
    .clk_in (pcif_clk_in), .rst_n (rst_n), .pd_req (pd_req),
    .stop_req (1'b0), .gclk (pcif_out)
  );

  clk_group_gate #(.WIDTH(NAUX)) u_aux (
    .clk_in (aux_clk_in), .rst_n (rst_n), .pd_req (pd_req),
    .stop_req (1'b0), .gclk (aux_out)
  );

  // Differential legs: stopped true leg low gives complement high.
  assign cpu_c = ~cpu_t;
  assign src_t = src_gclk;
  assign src_c = ~src_gclk;

  always_comb begin
    if (safe_req) begin
      freq_mode = SAFE_CODE;
    end else begin
      freq_mode = {held_straps.fs_b, held_straps.fs_a};
    end
  end

  assign vch_is48 = held_straps.vch48;
  assign usb_is24 = held_straps.usb24;

  logic unused_fn;
  assign unused_fn = ^pin_fn;

endmodule

// File: rtl/clkgate_strap_ctrl_chk.sv
`timescale 1ns/1ps
module clkgate_strap_ctrl_chk #(
  parameter int         NCPU      = 3,
  parameter int         NPCI      = 7,
  parameter logic [1:0] SAFE_CODE = 2'b00
) (
  input logic            ctl_clk,
  input logic            rst_n,
  input logic            pg_n,
  input logic            strap_fs_a,
  input logic            strap_fs_b,
  input logic            strap_vch,
  input logic            strap_usb,
  input logic            cfg_safe,
  input logic            shared_n,
  input logic            pci_stop_n,
  input logic            pci_clk_in,
  input logic            src_clk_in,
  input logic [NCPU-1:0] cpu_t,
  input logic [NCPU-1:0] cpu_c,
  input logic            src_t,
  input logic [NPCI-1:0] pci_out,
  input logic [1:0]      freq_mode,
  input logic            vch_is48,
  input logic            usb_is24
);

  // R1 / R3: captured while the qualifier is low
  assert_capture_R1: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!pg_n && shared_n) |=> (freq_mode == {$past(strap_fs_b), $past(strap_fs_a)}));

  assert_rate_sel_R3: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    !pg_n |=> (vch_is48 == $past(strap_vch)) && (usb_is24 == $past(strap_usb)));

  // R2: frozen while the qualifier is high
  assert_hold_R2: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    pg_n |=> $stable({vch_is48, usb_is24}));

  // R4: power-down stops everything
  assert_pwrdn_R4: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (!cfg_safe && !shared_n) |-> (cpu_t == '0) && (cpu_c == '1) && (pci_out == '0) && !src_t);

  // R5: safe request overrides the mode code
  assert_safe_R5: assert property (@(posedge ctl_clk) disable iff (!rst_n)
    (cfg_safe && !shared_n) |-> (freq_mode == SAFE_CODE));

  // R6: held stop request parks the PCI group
  assert_pci_park_R6: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
    ($past(!pci_stop_n, 1) && $past(!pci_stop_n, 2)) |-> (pci_out == '0));

  // R6: held stop request parks the serial-reference pair
  assert_src_park_R6: assert property (@(negedge src_clk_in) disable iff (!rst_n)
    ($past(!pci_stop_n, 1) && $past(!pci_stop_n, 2)) |-> !src_t);

endmodule

bind clkgate_strap_ctrl clkgate_strap_ctrl_chk #(
  .NCPU(NCPU), .NPCI(NPCI), .SAFE_CODE(SAFE_CODE)
) u_chk (.*);

// File: tb/clkgate_strap_ctrl_test.sv
`timescale 1ns/1ps
module clkgate_strap_ctrl_test;

  localparam int NCPU = 3, NPCI = 7, NPCIF = 3, NAUX = 4;
  localparam logic [1:0] SAFE = 2'b00;

  logic ctl_clk = 0, rst_n = 0, pg_n = 0;
  logic strap_fs_a = 0, strap_fs_b = 0, strap_vch = 0, strap_usb = 0;
  logic cfg_safe = 0, shared_n = 1, pci_stop_n = 1;
  logic cpu_clk_in = 0, src_clk_in = 0, pci_clk_in = 0, pcif_clk_in = 0, aux_clk_in = 0;
  logic [NCPU-1:0] cpu_t, cpu_c;
  logic src_t, src_c;
  logic [NPCI-1:0] pci_out;
  logic [NPCIF-1:0] pcif_out;
  logic [NAUX-1:0] aux_out;
  logic [1:0] freq_mode;
  logic vch_is48, usb_is24;

  int checks = 0, fails = 0, runts = 0;
  bit allow_short = 1;
  realtime rise_pci = 0, rise_cpu = 0;

  always #10  ctl_clk = ~ctl_clk;
  always #5   cpu_clk_in = ~cpu_clk_in;
  initial begin #2; forever #5 src_clk_in = ~src_clk_in; end
  always #15  pci_clk_in = ~pci_clk_in;
  initial begin #4; forever #15 pcif_clk_in = ~pcif_clk_in; end
  always #7.5 aux_clk_in = ~aux_clk_in;

  clkgate_strap_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .NPCIF(NPCIF), .NAUX(NAUX),
                       .SAFE_CODE(SAFE)) uut (.*);

  // R8: pulse-width monitors on gated outputs
  always @(posedge pci_out[0]) rise_pci = $realtime;
  always @(negedge pci_out[0]) if (!allow_short && ($realtime - rise_pci) < 14.5) runts++;
  always @(posedge cpu_t[0]) rise_cpu = $realtime;
  always @(negedge cpu_t[0]) if (!allow_short && ($realtime - rise_cpu) < 4.5) runts++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // g: 0 cpu, 1 src, 2 pci, 3 pcif, 4 aux. Sample just after the source rises.
  task automatic grp(input int g, input bit run, input string req);
    logic [31:0] act, exp;
    case (g)
      0: @(posedge cpu_clk_in);
      1: @(posedge src_clk_in);
      2: @(posedge pci_clk_in);
      3: @(posedge pcif_clk_in);
      default: @(posedge aux_clk_in);
    endcase
    #1;
    case (g)
      0: begin act = {cpu_c, cpu_t}; exp = run ? {{NCPU{1'b0}}, {NCPU{1'b1}}} : {{NCPU{1'b1}}, {NCPU{1'b0}}}; end
      1: begin act = {src_c, src_t}; exp = run ? 32'h1 : 32'h2; end
      2: begin act = pci_out; exp = run ? {NPCI{1'b1}} : '0; end
      3: begin act = pcif_out; exp = run ? {NPCIF{1'b1}} : '0; end
      default: begin act = aux_out; exp = run ? {NAUX{1'b1}} : '0; end
    endcase
    chk(act == exp, req, act, exp);
  endtask

  task automatic all_off_now(input string req);
    chk(cpu_t == '0 && cpu_c == '1, req, {cpu_c, cpu_t}, {{NCPU{1'b1}}, {NCPU{1'b0}}});
    chk(!src_t && src_c, req, {src_c, src_t}, 2);
    chk(pci_out == '0 && pcif_out == '0 && aux_out == '0, req, {aux_out, pcif_out, pci_out}, 0);
  endtask

  task automatic set_straps(input logic [3:0] v);
    {strap_usb, strap_vch, strap_fs_b, strap_fs_a} = v;
  endtask

  initial begin
    // R10: reset state
    #35;
    all_off_now("R10");
    chk(freq_mode == 2'b00 && !vch_is48 && !usb_is24, "R10", {freq_mode, vch_is48, usb_is24}, 0);
    @(negedge ctl_clk); rst_n = 1;
    repeat (4) @(negedge ctl_clk);
    allow_short = 0;

    // R1 / R3: exhaustive strap capture
    for (int v = 0; v < 16; v++) begin
      @(negedge ctl_clk); set_straps(v[3:0]); pg_n = 0;
      @(posedge ctl_clk); #1;
      chk(freq_mode == v[1:0], "R1", freq_mode, v[1:0]);
      chk(vch_is48 == v[2] && usb_is24 == v[3], "R3", {usb_is24, vch_is48}, v[3:2]);
    end
    // R2: freeze at 4'hA, sweep pins
    @(negedge ctl_clk); set_straps(4'hA);
    @(negedge ctl_clk); pg_n = 1;
    for (int v = 0; v < 16; v++) begin
      @(negedge ctl_clk); set_straps(v[3:0]);
      @(posedge ctl_clk); #1;
      chk(freq_mode == 2'b10 && vch_is48 == 0 && usb_is24 == 1, "R2",
          {usb_is24, vch_is48, freq_mode}, 4'b1010);
    end

    // R5: pin-function sweep (latched code 2'b10)
    for (int m = 0; m < 4; m++) begin
      @(negedge ctl_clk); cfg_safe = m[1]; shared_n = m[0];
      #1;
      if (m == 2) chk(freq_mode == SAFE, "R5", freq_mode, SAFE);
      else if (m != 0) chk(freq_mode == 2'b10, "R5", freq_mode, 2'b10);
      if (m == 0) begin
        allow_short = 1;
        all_off_now("R4");
      end
      repeat (6) @(negedge ctl_clk);
      if (m == 0) begin
        grp(0, 0, "R4"); grp(2, 0, "R4");
      end else begin
        grp(0, 1, "R5"); grp(2, 1, "R5"); grp(4, 1, "R5");
      end
      allow_short = 0;
    end
    cfg_safe = 0; shared_n = 1;

    // Safe request during strap capture
    @(negedge ctl_clk); cfg_safe = 1; shared_n = 0; pg_n = 0; set_straps(4'h3);
    @(posedge ctl_clk); #1;
    chk(freq_mode == SAFE, "R5", freq_mode, SAFE);
    @(negedge ctl_clk); pg_n = 1; shared_n = 1; #1;
    chk(freq_mode == 2'b11, "R1", freq_mode, 2'b11);
    cfg_safe = 0;

    // R6 / R7: PCI stop
    repeat (4) @(negedge pci_clk_in);
    pci_stop_n = 0;
    repeat (3) @(negedge pci_clk_in);
    grp(2, 0, "R6"); grp(2, 0, "R6"); grp(1, 0, "R6"); grp(1, 0, "R6");
    grp(3, 1, "R7"); grp(0, 1, "R7"); grp(4, 1, "R7");
    // R8: release
    pci_stop_n = 1;
    repeat (3) @(negedge pci_clk_in);
    grp(2, 1, "R8"); grp(1, 1, "R8");

    // R9: power-down and PCI stop together, release power-down first
    @(negedge ctl_clk);
    allow_short = 1; pci_stop_n = 0; shared_n = 0; #1;
    all_off_now("R4");
    repeat (5) @(negedge ctl_clk);
    shared_n = 1;
    allow_short = 0;
    repeat (5) @(negedge ctl_clk);
    grp(0, 1, "R9"); grp(3, 1, "R9"); grp(4, 1, "R9");
    grp(2, 0, "R9"); grp(1, 0, "R9");
    pci_stop_n = 1;
    repeat (3) @(negedge pci_clk_in);
    grp(2, 1, "R9"); grp(1, 1, "R9");

    repeat (10) @(negedge ctl_clk);
    chk(runts == 0, "R8", runts, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule